// File: doc/BRIEF.md
# Statistics Counter Endpoint with Export Filters

This block is a statistics point placed inside a simulation model. At its core is an event counter that a command port can read and write like a plain register, so it can stand in for an existing register without changing the surrounding logic. The counter advances by one on each cycle in which the event input is high.

Next to the counter sits a small export filter. It decides when a record is pushed onto a ready/valid output stream. The filter can send a record every N cycles, when the counter wraps, or on increments while a gate has been toggled on. It can also be switched off. Apart from the filter, a command can arm a precise read that fires when the model's target time reaches a chosen value. Each record carries a fixed source identifier, the target time of the cycle that produced it, a kind code and the counter value.

The output has a one-record holding slot. A record produced while the slot is still full and not draining is dropped. The drop raises a sticky loss flag, so the export is either lossless or the loss is visible.

Top module: `stat_endpoint`

## Requirements
- R1: After a synchronous reset the counter, filter mode and period register are zero, no record or response is valid, and the loss flag is low.
- R2: A command with op 01 (write) loads register address 0 (counter), 1 (mode, low two bits) or 2 (period N). A command with op 00 (read) returns, one cycle later with `rsp_valid` high for that single cycle, the addressed register's value as it stood before that edge, zero-extended. Address 3 reads as zero.
- R3: Each cycle with `evt_inc` high adds one to the counter, wrapping at its width. A counter write in the same cycle wins, and the increment is lost.
- R4: With mode 01, a record of kind 01 is produced on the N-th cycle after the cycle that last wrote the mode or period, and every N cycles after that. A period of 0 behaves as 1.
- R5: With mode 10, a record of kind 10 is produced in the cycle in which an increment wraps the counter from all-ones to zero. A write in that cycle suppresses the wrap.
- R6: With mode 11, a pulse on `gate_tgl` flips an emission enable, and a mode write clears it. While the enable is set, every cycle with `evt_inc` high produces a record of kind 11.
- R7: With mode 00, no filter record is ever produced, whatever the increments, wraps or gate pulses.
- R8: Op 10 arms a timed read for the target time in `cmd_wdata`, replacing any earlier one. From the next cycle, the first cycle whose `tgt_time` equals it produces a record of kind 00 and disarms, in any mode.
- R9: Each record holds `SRC_ID`, the `tgt_time` of the producing cycle, and the counter value after that cycle's update. It becomes valid on the following cycle.
- R10: While `rec_valid` is high and `rec_ready` is low, the record stays valid and unchanged.
- R11: A record produced while the slot holds one that is not taken in that cycle is dropped and sets `ovf_flag`, which stays high until reset. A record produced in the cycle the slot drains replaces it with no loss.
- R12: When a timed read and a filter record fall in the same cycle, a single record of kind 00 is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_inc | input | 1 | Event: increment counter |
| gate_tgl | input | 1 | Pulse flips the gated-emission enable |
| tgt_time | input | TIME_W | Current target time of the model |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 00 read, 01 write, 10 timed read, 11 ignored |
| cmd_addr | input | 2 | Register select: 0 counter, 1 mode, 2 period |
| cmd_wdata | input | DATA_W | Write data or armed target time |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | DATA_W | Read response data |
| rec_valid | output | 1 | Output record valid |
| rec_ready | input | 1 | Downstream accepts record |
| rec_src | output | ID_W | Source identifier |
| rec_kind | output | 2 | 00 timed, 01 periodic, 10 rollover, 11 gated |
| rec_time | output | TIME_W | Target time of the record |
| rec_value | output | CNT_W | Counter value |
| ovf_flag | output | 1 | Sticky record-loss flag |

## Verification
A corrupted counter shows up in the very next read response or the next record's value field. A wrong period phase shifts record spacing within N cycles, a stray gate enable shows on the next increment, and a stale armed time either emits at the wrong target time or never emits. The bench runs a behavioural model in step with the design and compares every output port on every cycle. A divergence in hidden state is therefore reported in the first cycle it reaches a port, not at the end of a phase.

// File: rtl/stat_pkg.sv
package stat_pkg;

    typedef enum logic [1:0] {
        FLT_OFF   = 2'b00,
        FLT_EVERY = 2'b01,
        FLT_ROLL  = 2'b10,
        FLT_GATE  = 2'b11
    } flt_mode_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_TIMED = 2'b10,
        OP_NONE  = 2'b11
    } cmd_op_e;

    localparam logic [1:0] ADDR_COUNT  = 2'd0;
    localparam logic [1:0] ADDR_MODE   = 2'd1;
    localparam logic [1:0] ADDR_PERIOD = 2'd2;

    localparam logic [1:0] KIND_TIMED = 2'b00;

    // last phase value of the period counter; zero period acts as one
    function automatic logic [15:0] period_last(input logic [15:0] per);
        return (per == 16'd0) ? 16'd0 : per - 16'd1;
    endfunction

endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nx,
    output logic             wrap
);
    always_comb begin
        cnt_nx = cnt_q;
        wrap   = 1'b0;
        if (wr_en) begin
            cnt_nx = wr_data;
        end else if (inc) begin
            cnt_nx = cnt_q + 1'b1;
            wrap   = &cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_nx;
    end

    p_write_wins_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cnt_q == $past(wr_data));

    p_inc_step_r3: assert property (@(posedge clk) disable iff (rst)
        (inc && !wr_en) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    p_wrap_zero_r5: assert property (@(posedge clk) disable iff (rst)
        wrap |=> cnt_q == '0);

endmodule

// File: rtl/stat_trigger.sv
module stat_trigger
    import stat_pkg::*;
#(
    parameter int TIME_W = 16,
    parameter int PER_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [1:0]        mode_d,
    input  logic              per_wr,
    input  logic [PER_W-1:0]  per_d,
    input  logic              arm,
    input  logic [TIME_W-1:0] arm_time,
    input  logic              gate_tgl,
    input  logic              inc,
    input  logic              wrap,
    input  logic [TIME_W-1:0] tgt_time,
    output logic              fire,
    output logic [1:0]        kind,
    output logic [1:0]        mode_out,
    output logic [PER_W-1:0]  per_out
);
    flt_mode_e         mode_q;
    logic [PER_W-1:0]  per_q;
    logic [PER_W-1:0]  pc_q;
    logic [PER_W-1:0]  pc_last;
    logic              gen_q;
    logic              pend_q;
    logic [TIME_W-1:0] ptime_q;
    logic              hit;
    logic              pf;

    assign pc_last  = PER_W'(period_last(16'(per_q)));
    assign mode_out = mode_q;
    assign per_out  = per_q;

    always_comb begin
        hit = pend_q && (tgt_time == ptime_q);
        case (mode_q)
            FLT_EVERY: pf = (pc_q == pc_last);
            FLT_ROLL:  pf = wrap;
            FLT_GATE:  pf = gen_q & inc;
            default:   pf = 1'b0;
        endcase
        fire = hit | pf;
        kind = hit ? KIND_TIMED : mode_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= FLT_OFF;
            per_q   <= '0;
            pc_q    <= '0;
            gen_q   <= 1'b0;
            pend_q  <= 1'b0;
            ptime_q <= '0;
        end else begin
            if (mode_wr) mode_q <= flt_mode_e'(mode_d);
            if (per_wr)  per_q  <= per_d;

            if (mode_wr || per_wr)       pc_q <= '0;
            else if (mode_q == FLT_EVERY) pc_q <= pf ? '0 : pc_q + 1'b1;
            else                          pc_q <= '0;

            if (mode_wr)       gen_q <= 1'b0;
            else if (gate_tgl) gen_q <= ~gen_q;

            if (arm) begin
                pend_q  <= 1'b1;
                ptime_q <= arm_time;
            end else if (hit) begin
                pend_q  <= 1'b0;
            end
        end
    end

    p_off_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == FLT_OFF && !pend_q) |-> !fire);

    p_timed_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (fire && kind == KIND_TIMED && !arm) |=> !pend_q);

    p_gate_needs_inc_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && kind == 2'b11) |-> inc);

endmodule

// File: rtl/stat_outslot.sv
module stat_outslot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_req,
    input  logic [W-1:0] load_data,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         ovf
);
    logic drain;
    logic take;

    assign drain = out_valid & out_ready;
    assign take  = load_req & (~out_valid | drain);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            ovf       <= 1'b0;
        end else begin
            if (take) begin
                out_valid <= 1'b1;
                out_data  <= load_data;
            end else if (drain) begin
                out_valid <= 1'b0;
            end
            if (load_req && !take) ovf <= 1'b1;
        end
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_no_overflow_clear_r11: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    p_drop_flags_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && load_req) |=> ovf);

endmodule

// File: rtl/stat_endpoint.sv
module stat_endpoint
    import stat_pkg::*;
#(
    parameter int              ID_W   = 4,
    parameter logic [ID_W-1:0] SRC_ID = 4'hA,
    parameter int              CNT_W  = 8,
    parameter int              TIME_W = 16,
    parameter int              PER_W  = 8,
    parameter int              DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_inc,
    input  logic              gate_tgl,
    input  logic [TIME_W-1:0] tgt_time,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [1:0]        cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rec_valid,
    input  logic              rec_ready,
    output logic [ID_W-1:0]   rec_src,
    output logic [1:0]        rec_kind,
    output logic [TIME_W-1:0] rec_time,
    output logic [CNT_W-1:0]  rec_value,
    output logic              ovf_flag
);
    typedef struct packed {
        logic [ID_W-1:0]   src;
        logic [1:0]        kind;
        logic [TIME_W-1:0] stamp;
        logic [CNT_W-1:0]  value;
    } rec_t;

    localparam int REC_W = $bits(rec_t);

    logic              is_rd, is_wr, is_arm;
    logic              cnt_wr, mode_wr, per_wr;
    logic [CNT_W-1:0]  cnt_q, cnt_nx;
    logic              wrap, fire;
    logic [1:0]        kind, mode_q;
    logic [PER_W-1:0]  per_q;
    logic [DATA_W-1:0] rd_mux;
    rec_t              rec_in, rec_out;
    logic [REC_W-1:0]  slot_q;

    assign is_rd   = cmd_valid && (cmd_op == OP_READ);
    assign is_wr   = cmd_valid && (cmd_op == OP_WRITE);
    assign is_arm  = cmd_valid && (cmd_op == OP_TIMED);
    assign cnt_wr  = is_wr && (cmd_addr == ADDR_COUNT);
    assign mode_wr = is_wr && (cmd_addr == ADDR_MODE);
    assign per_wr  = is_wr && (cmd_addr == ADDR_PERIOD);

    stat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .inc(evt_inc), .wr_en(cnt_wr),
        .wr_data(cmd_wdata[CNT_W-1:0]), .cnt_q(cnt_q), .cnt_nx(cnt_nx), .wrap(wrap)
    );

    stat_trigger #(.TIME_W(TIME_W), .PER_W(PER_W)) u_trig (
        .clk(clk), .rst(rst),
        .mode_wr(mode_wr), .mode_d(cmd_wdata[1:0]),
        .per_wr(per_wr), .per_d(cmd_wdata[PER_W-1:0]),
        .arm(is_arm), .arm_time(cmd_wdata[TIME_W-1:0]),
        .gate_tgl(gate_tgl), .inc(evt_inc), .wrap(wrap), .tgt_time(tgt_time),
        .fire(fire), .kind(kind), .mode_out(mode_q), .per_out(per_q)
    );

    always_comb begin
        rec_in.src   = SRC_ID;
        rec_in.kind  = kind;
        rec_in.stamp = tgt_time;
        rec_in.value = cnt_nx;
    end

    stat_outslot #(.W(REC_W)) u_slot (
        .clk(clk), .rst(rst), .load_req(fire), .load_data(rec_in),
        .out_ready(rec_ready), .out_valid(rec_valid), .out_data(slot_q), .ovf(ovf_flag)
    );

    assign rec_out   = rec_t'(slot_q);
    assign rec_src   = rec_out.src;
    assign rec_kind  = rec_out.kind;
    assign rec_time  = rec_out.stamp;
    assign rec_value = rec_out.value;

    always_comb begin
        rd_mux = '0;
        case (cmd_addr)
            ADDR_COUNT:  rd_mux[CNT_W-1:0] = cnt_q;
            ADDR_MODE:   rd_mux[1:0]       = mode_q;
            ADDR_PERIOD: rd_mux[PER_W-1:0] = per_q;
            default:     rd_mux            = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= is_rd;
            if (is_rd) rsp_data <= rd_mux;
        end
    end

    p_rsp_follows_read_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_READ) |=> rsp_valid);

    p_rsp_only_on_read_r2: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && cmd_op == OP_READ) |=> !rsp_valid);

    p_record_source_r9: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> rec_src == SRC_ID);

endmodule

// File: tb/sim_stat_endpoint.sv
module sim_stat_endpoint;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_inc = 1'b0;
    logic        gate_tgl = 1'b0;
    logic [15:0] tgt_time = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [1:0]  cmd_addr = 2'b00;
    logic [15:0] cmd_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic        rec_valid;
    logic        rec_ready = 1'b1;
    logic [3:0]  rec_src;
    logic [1:0]  rec_kind;
    logic [15:0] rec_time;
    logic [7:0]  rec_value;
    logic        ovf_flag;

    always #10 clk = ~clk;

    stat_endpoint u0 (
        .clk(clk), .rst(rst), .evt_inc(evt_inc), .gate_tgl(gate_tgl), .tgt_time(tgt_time),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_src(rec_src), .rec_kind(rec_kind), .rec_time(rec_time), .rec_value(rec_value),
        .ovf_flag(ovf_flag)
    );

    int    total = 0;
    int    bad = 0;
    int    tt = 100;
    bit    hold_t = 0;
    string cur_tag = "R1";
    int    recs = 0;

    // behavioural reference state
    int m_cnt = 0, m_mode = 0, m_per = 0, m_pc = 0, m_gen = 0;
    int m_pend = 0, m_ptime = 0;
    int m_sv = 0, m_rk = 0, m_rt = 0, m_rv = 0, m_ovf = 0;
    int m_rspv = 0, m_rspd = 0;

    always @(posedge clk) begin
        int nc, lim, wrp, hit, pf, fire, kd, drain;
        bit wr, rd, ar;
        if (rst) begin
            m_cnt = 0; m_mode = 0; m_per = 0; m_pc = 0; m_gen = 0;
            m_pend = 0; m_ptime = 0; m_sv = 0; m_ovf = 0; m_rspv = 0; m_rspd = 0;
        end else begin
            wr = cmd_valid && cmd_op == 2'b01;
            rd = cmd_valid && cmd_op == 2'b00;
            ar = cmd_valid && cmd_op == 2'b10;
            nc = m_cnt; wrp = 0;
            if (wr && cmd_addr == 0) nc = int'(cmd_wdata) % 256;
            else if (evt_inc) begin nc = (m_cnt + 1) % 256; wrp = (m_cnt == 255); end
            hit = m_pend && (int'(tgt_time) == m_ptime);
            lim = (m_per == 0) ? 1 : m_per;
            case (m_mode)
                1: pf = (m_pc == lim - 1);
                2: pf = wrp;
                3: pf = m_gen && evt_inc;
                default: pf = 0;
            endcase
            fire = hit || pf;
            kd = hit ? 0 : m_mode;
            m_rspv = rd;
            if (rd) m_rspd = (cmd_addr == 0) ? m_cnt : (cmd_addr == 1) ? m_mode :
                             (cmd_addr == 2) ? m_per : 0;
            drain = m_sv && rec_ready;
            if (fire) begin
                if (!m_sv || drain) begin
                    m_sv = 1; m_rk = kd; m_rt = int'(tgt_time); m_rv = nc;
                end else m_ovf = 1;
            end else if (drain) m_sv = 0;
            if (wr && (cmd_addr == 1 || cmd_addr == 2)) m_pc = 0;
            else if (m_mode == 1) m_pc = pf ? 0 : m_pc + 1;
            else m_pc = 0;
            if (wr && cmd_addr == 1) m_gen = 0;
            else if (gate_tgl) m_gen = !m_gen;
            if (ar) begin m_pend = 1; m_ptime = int'(cmd_wdata); end
            else if (hit) m_pend = 0;
            if (wr && cmd_addr == 1) m_mode = int'(cmd_wdata) % 4;
            if (wr && cmd_addr == 2) m_per = int'(cmd_wdata) % 256;
            m_cnt = nc;
        end
    end

    task automatic chk(input string tag, input string what, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
        end
    endtask

    task automatic compare();
        chk(cur_tag, "rec_valid", int'(rec_valid), m_sv);
        if (m_sv != 0) begin
            recs++;
            chk("R9", "rec_src", int'(rec_src), 10);
            chk("R9", "rec_time", int'(rec_time), m_rt);
            chk(cur_tag, "rec_kind", int'(rec_kind), m_rk);
            chk(cur_tag, "rec_value", int'(rec_value), m_rv);
        end
        chk(cur_tag, "rsp_valid", int'(rsp_valid), m_rspv);
        if (m_rspv != 0) chk("R2", "rsp_data", int'(rsp_data), m_rspd);
        chk("R11", "ovf_flag", int'(ovf_flag), m_ovf);
    endtask

    task automatic drv(input bit inc, input bit tgl, input bit rdy,
                       input bit cv, input logic [1:0] op, input logic [1:0] ad, input int wd);
        evt_inc = inc; gate_tgl = tgl; rec_ready = rdy;
        cmd_valid = cv; cmd_op = op; cmd_addr = ad; cmd_wdata = wd[15:0];
        tgt_time = tt[15:0];
        if (!hold_t) tt++;
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n, input bit inc, input bit rdy);
        for (int i = 0; i < n; i++) drv(inc, 1'b0, rdy, 1'b0, 2'b00, 2'b00, 0);
    endtask

    task automatic wreg(input logic [1:0] ad, input int d, input bit inc);
        drv(inc, 1'b0, 1'b1, 1'b1, 2'b01, ad, d);
    endtask

    task automatic rreg(input logic [1:0] ad);
        drv(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, ad, 0);
    endtask

    task automatic arm(input int t);
        drv(1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 2'b00, t);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL R1 watchdog got=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        cur_tag = "R1";
        idle(3, 1'b1, 1'b1);
        rst = 1'b0;
        rreg(2'd0); rreg(2'd1); rreg(2'd2);
        idle(1, 1'b0, 1'b1);

        // R2 register access
        cur_tag = "R2";
        wreg(2'd0, 16'h0055, 1'b0);
        rreg(2'd0);
        wreg(2'd2, 16'h0007, 1'b0);
        rreg(2'd2); rreg(2'd1); rreg(2'd3);
        drv(1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 2'd0, 16'h00EE);
        rreg(2'd0);
        idle(1, 1'b0, 1'b1);

        // R3 increment and write priority
        cur_tag = "R3";
        wreg(2'd0, 16'h0010, 1'b1);
        rreg(2'd0);
        idle(3, 1'b1, 1'b1);
        rreg(2'd0);
        drv(1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 2'd0, 0);
        rreg(2'd0);

        // R7 filter off
        cur_tag = "R7";
        wreg(2'd0, 16'h00FE, 1'b0);
        idle(4, 1'b1, 1'b1);
        drv(1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 2'd0, 0);
        idle(3, 1'b1, 1'b1);
        drv(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 2'd0, 0);

        // R4 every N cycles
        cur_tag = "R4";
        wreg(2'd2, 3, 1'b0);
        wreg(2'd1, 1, 1'b0);
        for (int i = 0; i < 12; i++) drv(i[0], 1'b0, 1'b1, 1'b0, 2'b00, 2'd0, 0);
        wreg(2'd2, 0, 1'b0);
        idle(4, 1'b1, 1'b1);
        wreg(2'd2, 5, 1'b1);
        idle(11, 1'b0, 1'b1);

        // R10 backpressure hold
        cur_tag = "R10";
        wreg(2'd2, 4, 1'b0);
        idle(4, 1'b0, 1'b1);
        idle(3, 1'b1, 1'b0);
        idle(4, 1'b0, 1'b1);

        // R11 loss and same-cycle replacement
        cur_tag = "R11";
        wreg(2'd2, 1, 1'b0);
        idle(3, 1'b1, 1'b1);
        idle(3, 1'b1, 1'b0);
        idle(3, 1'b0, 1'b1);

        // R5 rollover
        cur_tag = "R5";
        wreg(2'd1, 2, 1'b0);
        wreg(2'd0, 16'h00FD, 1'b0);
        idle(5, 1'b1, 1'b1);
        wreg(2'd0, 16'h00FF, 1'b0);
        wreg(2'd0, 16'h0030, 1'b1);
        idle(2, 1'b1, 1'b1);
        wreg(2'd0, 16'h00FF, 1'b0);
        drv(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 2'd0, 0);
        idle(3, 1'b1, 1'b1);

        // R6 gated emission
        cur_tag = "R6";
        wreg(2'd1, 3, 1'b0);
        idle(3, 1'b1, 1'b1);
        drv(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 2'd0, 0);
        idle(3, 1'b1, 1'b1);
        drv(1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 2'd0, 0);
        idle(3, 1'b1, 1'b1);
        drv(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 2'd0, 0);
        idle(2, 1'b1, 1'b1);
        wreg(2'd1, 3, 1'b0);
        idle(3, 1'b1, 1'b1);

        // R8 timed read
        cur_tag = "R8";
        wreg(2'd1, 0, 1'b0);
        arm(tt + 4);
        idle(8, 1'b1, 1'b1);
        arm(tt - 2);
        idle(5, 1'b1, 1'b1);
        arm(tt + 9);
        arm(tt + 2);
        idle(12, 1'b1, 1'b1);
        arm(tt + 2);
        idle(1, 1'b1, 1'b1);
        hold_t = 1'b1;
        idle(5, 1'b1, 1'b1);
        hold_t = 1'b0;
        wreg(2'd1, 2, 1'b0);
        arm(tt + 3);
        idle(6, 1'b1, 1'b1);

        // R12 timed read coinciding with a periodic record
        cur_tag = "R12";
        wreg(2'd2, 1, 1'b0);
        wreg(2'd1, 1, 1'b0);
        arm(tt + 3);
        idle(6, 1'b1, 1'b1);
        wreg(2'd1, 0, 1'b0);
        idle(3, 1'b0, 1'b1);

        chk("R9", "records_observed_nonzero", int'(recs > 20), 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule